// File: doc/BRIEF.md
# Segmented Carry-Pipelined Phase Accumulator

This block produces the running phase word of a numerically controlled oscillator. Every clock it adds a 32-bit tuning word to its phase, modulo 2^32. The adder is split into four segments so that no single clock period holds a full 32-bit carry chain. From least to most significant, the segments are 12, 7, 7 and 6 bits wide. Each segment works one clock later than the one below it. It takes the registered carry of the lower segment and adds it to its own slice of the tuning word.

A new tuning word is taken in on a one-cycle load strobe. The lowest segment uses it on the same clock edge. Each higher segment receives its slice preset through a short staggered delay, so it changes word on exactly the step that its delayed addition belongs to. The output therefore shows a clean change of step size on one edge, with no stretch of mixed or repeated increments.

Alignment registers bring the lower segments back into line with the top segment. A valid flag marks the end of pipeline fill after reset.

Top module: `pvpa_phase_acc`

## Requirements
- R1: The accumulator is split into segments of 12, 7, 7 and 6 bits, starting at phase bits 0, 12, 19 and 26. Carries cross every segment boundary, so the output equals an unsegmented 32-bit sum.
- R2: While `rst` is high at a rising clock edge, `phase` becomes 0 and `phase_valid` becomes 0. The tuning word is cleared to 0. A `load` strobe on that edge has no effect.
- R3: `phase_valid` goes high after exactly three rising edges with `rst` low following a reset edge. It stays high until the next reset.
- R4: While the tuning word is constant, each edge adds that word to `phase`, modulo 2^32.
- R5: A word taken with `load` at edge n sets the step `phase` makes on edge n+3. The step on edge n+2 still uses the previous word.
- R6: When `load` is low, the value on `tuning_word` has no effect on `phase`.
- R7: Loads on consecutive edges each set exactly one step, in the order they were given.
- R8: Sums that pass 2^32 wrap around with no lost or extra carry. This includes words at or near 0xFFFFFFFF.
- R9: After a reset in mid-run, `phase` stays 0 until a new word is loaded, whatever value sits on `tuning_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Take `tuning_word` as the new step size on this edge |
| tuning_word | input | 32 | Phase increment per clock, unsigned modulo 2^32 |
| phase | output | 32 | Phase word, driven straight from registers |
| phase_valid | output | 1 | High once the segment pipeline has filled after reset |

## Verification
A lost or doubled carry in any segment appears as a step in `phase` that is off by a power of two at that segment's base bit (2^12, 2^19 or 2^26). It shows up at most three edges after the bad addition. A word preset that reaches a segment one edge early or late gives a single step that blends the old and new words, exactly three edges after the load. A stale alignment register shows as a repeated or skipped low-order pattern in the very next output word. The bench compares every clock against a plain 32-bit reference sum delayed by three edges, so each of these faults is caught on the first wrong word.

// File: rtl/pvpa_pkg.sv
`timescale 1ns/1ps
package pvpa_pkg;
  localparam int NSEG = 4;

  typedef int unsigned seg_w_t [NSEG];

  // Base bit of segment k: the summed widths of the segments below it
  function automatic int unsigned seg_lsb(seg_w_t w, int unsigned k);
    int unsigned acc;
    acc = 0;
    for (int i = 0; i < NSEG; i++) begin
      if (i < int'(k)) acc += w[i];
    end
    return acc;
  endfunction

  function automatic int unsigned total_w(seg_w_t w);
    int unsigned acc;
    acc = 0;
    for (int i = 0; i < NSEG; i++) acc += w[i];
    return acc;
  endfunction
endpackage

// File: rtl/pvpa_delay.sv
`timescale 1ns/1ps
// Fixed-depth register line with synchronous clear; depth 0 is a wire
module pvpa_delay #(
  parameter int unsigned W     = 1,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (DEPTH == 0) begin : g_wire
      logic unused_ctl;
      assign unused_ctl = clk ^ rst;
      assign dout = din;
    end else begin : g_regs
      logic [W-1:0] stage_q [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < int'(DEPTH); i++) stage_q[i] <= '0;
        end else begin
          stage_q[0] <= din;
          for (int i = 1; i < int'(DEPTH); i++) stage_q[i] <= stage_q[i-1];
        end
      end
      assign dout = stage_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/pvpa_segment.sv
`timescale 1ns/1ps
// One accumulator slice: holds its own word slice, adds it with the
// registered carry from the slice below, and registers its carry out.
module pvpa_segment #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] slice,
  input  logic         cin,
  output logic [W-1:0] sum_q,
  output logic         cout_q
);
  logic [W-1:0] word_q;
  logic [W-1:0] addend;
  logic [W:0]   total;

  // A preset slice is used on the edge it arrives, not one edge later
  always_comb begin
    addend = ld ? slice : word_q;
    total  = {1'b0, sum_q} + {1'b0, addend} + {{W{1'b0}}, cin};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      sum_q  <= '0;
      cout_q <= 1'b0;
    end else begin
      if (ld) word_q <= slice;
      sum_q  <= total[W-1:0];
      cout_q <= total[W];
    end
  end

  // R1: a carry out means the slice wrapped, so it cannot have grown
  assert_carry_wraps_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cout_q) |-> (sum_q <= $past(sum_q)));
  // R1: no carry out means the slice did not wrap
  assert_no_carry_grows_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !cout_q) |-> (sum_q >= $past(sum_q)));
  // R6: the held word slice changes only through a preset
  assert_word_held_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ld)) |-> $stable(word_q));
endmodule

// File: rtl/pvpa_phase_acc.sv
`timescale 1ns/1ps
module pvpa_phase_acc
  import pvpa_pkg::*;
#(
  parameter seg_w_t SEG_W = '{12, 7, 7, 6},
  localparam int unsigned PHASE_W = total_w(SEG_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [PHASE_W-1:0] tuning_word,
  output logic [PHASE_W-1:0] phase,
  output logic               phase_valid
);
  localparam int unsigned FILL_W = $clog2(NSEG);
  localparam logic [FILL_W-1:0] FILL_END = FILL_W'(NSEG - 1);

  logic [NSEG:0] carry;
  assign carry[0] = 1'b0;

  logic unused_top_carry;
  assign unused_top_carry = carry[NSEG];

  generate
    for (genvar k = 0; k < NSEG; k++) begin : g_seg
      localparam int unsigned SW  = SEG_W[k];
      localparam int unsigned LSB = seg_lsb(SEG_W, k);

      logic [SW:0]   pre_in;
      logic [SW:0]   pre_out;
      logic [SW-1:0] seg_sum;

      assign pre_in = {load, tuning_word[LSB +: SW]};

      // Staggered preset: slice k of a new word and its strobe arrive k edges late
      pvpa_delay #(.W(SW + 1), .DEPTH(k)) u_preset (
        .clk (clk),
        .rst (rst),
        .din (pre_in),
        .dout(pre_out)
      );

      pvpa_segment #(.W(SW)) u_seg (
        .clk   (clk),
        .rst   (rst),
        .ld    (pre_out[SW]),
        .slice (pre_out[SW-1:0]),
        .cin   (carry[k]),
        .sum_q (seg_sum),
        .cout_q(carry[k+1])
      );

      // Alignment: lower slices wait for the top slice to catch up
      pvpa_delay #(.W(SW), .DEPTH(NSEG - 1 - k)) u_align (
        .clk (clk),
        .rst (rst),
        .din (seg_sum),
        .dout(phase[LSB +: SW])
      );
    end
  endgenerate

  logic [FILL_W-1:0] fill_q;
  always_ff @(posedge clk) begin
    if (rst)                  fill_q <= '0;
    else if (fill_q != FILL_END) fill_q <= fill_q + FILL_W'(1);
  end
  assign phase_valid = (fill_q == FILL_END);

  // R3: valid, once up, holds until reset
  assert_valid_hold_R3: assert property (@(posedge clk) disable iff (rst)
    phase_valid |=> phase_valid);
  // R3: valid needs three reset-free edges behind it
  assert_valid_fill_R3: assert property (@(posedge clk) disable iff (rst)
    phase_valid |-> (!$past(rst) && !$past(rst, 2) && !$past(rst, 3)));
  // R4: with no load behind this step, the step size repeats
  assert_step_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (phase_valid && $past(phase_valid, 3) && !$past(load, 4)) |->
      ((phase - $past(phase)) == ($past(phase) - $past(phase, 2))));
  // R5: the step three edges after a load equals the loaded word
  assert_load_take_R5: assert property (@(posedge clk) disable iff (rst)
    (phase_valid && $past(phase_valid, 3) && $past(load, 4)) |->
      ((phase - $past(phase)) == $past(tuning_word, 4)));
endmodule

// File: tb/sim_pvpa_phase_acc.sv
`timescale 1ns/1ps
module sim_pvpa_phase_acc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [31:0] tuning_word = '0;
  logic [31:0] phase;
  logic        phase_valid;

  always #2.5 clk = ~clk;

  pvpa_phase_acc u0 (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .tuning_word(tuning_word),
    .phase      (phase),
    .phase_valid(phase_valid)
  );

  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string tag = "R2";

  // Reference: plain 32-bit running sum, history of the last four sums
  logic [31:0] m_word;
  logic [31:0] m_hist [4];
  int          m_fill;

  always @(posedge clk) begin
    if (rst) begin
      m_word = '0;
      for (int i = 0; i < 4; i++) m_hist[i] = '0;
      m_fill = 0;
    end else begin
      if (load) m_word = tuning_word;
      for (int i = 3; i > 0; i--) m_hist[i] = m_hist[i-1];
      m_hist[0] = m_hist[1] + m_word;
      if (m_fill < 3) m_fill++;
    end
  end

  task automatic check32(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic check1(input string t, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s valid: actual %b expected %b at %0t", t, act, exp, $time);
    end
  endtask

  // Drive, wait one edge, sample 1 ns later against the reference
  task automatic tick(input bit ld, input logic [31:0] w);
    load = ld;
    tuning_word = w;
    @(posedge clk);
    #1;
    check32(tag, phase, m_hist[3]);
    check1(tag, phase_valid, m_fill >= 3);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  initial begin
    logic [31:0] p1, p2, p3, lfsr;
    // R2: reset state, load during reset ignored
    tag = "R2";
    tick(0, 32'h5);
    tick(1, 32'h1234);
    tick(0, 32'h0);
    check32("R2", phase, 32'h0);
    check1("R2", phase_valid, 1'b0);

    // R3: fill timing of valid
    rst = 1'b0;
    tag = "R3";
    repeat (5) tick(0, 32'h0);

    // R4: steady accumulation
    tag = "R4";
    tick(1, 32'h0123_4567);
    repeat (20) tick(0, 32'h0);

    // R6: tuning_word toggles without load
    tag = "R6";
    for (int i = 0; i < 12; i++) tick(0, 32'h9E37_79B9 * (i + 1));

    // R5: explicit step-change latency
    tag = "R5";
    tick(1, 32'h0000_0100);
    tick(0, 32'hDEAD_BEEF); p1 = phase;
    tick(0, 32'hDEAD_BEEF); p2 = phase;
    tick(0, 32'hDEAD_BEEF); p3 = phase;
    check32("R5 old step", p2 - p1, 32'h0123_4567);
    check32("R5 new step", p3 - p2, 32'h0000_0100);
    repeat (4) tick(0, 32'h0);

    // R7: back-to-back loads
    tag = "R7";
    for (int i = 0; i < 8; i++) tick(1, 32'h1111_1111 * (i + 1));
    repeat (6) tick(0, 32'h0);

    // R8: wraparound
    tag = "R8";
    tick(1, 32'hF000_0001);
    repeat (20) tick(0, 32'h0);
    tick(1, 32'hFFFF_FFFF);
    repeat (10) tick(0, 32'h0);

    // R1: carries across bits 12, 19 and 26
    tag = "R1";
    tick(1, 32'h0000_0FFF); repeat (30) tick(0, 32'h0);
    tick(1, 32'h0007_F001); repeat (30) tick(0, 32'h0);
    tick(1, 32'h03F8_0001); repeat (30) tick(0, 32'h0);
    tick(1, 32'h03FF_FFFF); repeat (30) tick(0, 32'h0);

    // R9: reset mid-run, then no load
    tag = "R9";
    rst = 1'b1;
    tick(1, 32'h7777_7777);
    tick(1, 32'h7777_7777);
    rst = 1'b0;
    repeat (12) tick(0, 32'h0000_1234);
    check32("R9", phase, 32'h0);

    // R4: mixed pattern, a load every seventh edge
    tag = "R4";
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 80; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      tick((i % 7) == 0, lfsr);
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule